// File: doc/BRIEF.md
# Circulating Serial Word Register

This block stores one data word as a serial bit stream that travels around a closed loop of clocked delay stages. The loop is exactly one word time long. A word time is made of a run of information slots followed by a short gap of idle slots. The stream passes a single output tap. A free-running slot counter marks which bit position is at the tap. Each clock edge counts as one pulse time, and each stored bit takes exactly one slot.

The loop has three modes. In the idle mode the tap output is fed straight back, so the word comes round unchanged. A load opens an input gate and closes the recirculation path for one circulation, so the new bits take the place of the old ones in the same slots. A shift lengthens or shortens the loop by a few pulse times for one circulation. Every bit then lands earlier or later in the word, and the circulation after that runs at normal length again. Requests are taken only at the word boundary. A one-cycle completion pulse follows the circulation that carried a load or a shift.

Top module: `circ_word_reg`

## Requirements
- R1: The slot counter `slot` steps by one on every clock, runs from 0 to 19 and wraps from 19 back to 0.
- R2: While and just after reset, `slot` is 0, `ser_out` is 0 and `word_done` is 0. The stored word is all zeros.
- R3: With no request, the word comes round unchanged. Word bit i (bit 0 is the least significant) appears on `ser_out` while `slot` equals i, in every circulation.
- R4: In the gap slots 16 to 19, `ser_out` is always 0.
- R5: A `load_req` high in the cycle where `slot` is 19 loads a new word in the next circulation. The value of `ser_in` while `slot` is i (i from 0 to 15) becomes bit i, and the old word is dropped completely.
- R6: `load_req` or `shift_req` high in any cycle where `slot` is not 19 has no effect. `ser_in` has no effect outside a load circulation.
- R7: A `shift_req` with `shift_left` at 0 and amount k (0 to 3) on `shift_amt`, taken at slot 19, turns word v into v >> k. The top k bits become 0.
- R8: A `shift_req` with `shift_left` at 1 and amount k turns word v into (v << k) mod 2^16. Bits moved past bit 15 are lost, and the low k bits become 0.
- R9: If `load_req` and `shift_req` are both high at slot 19, only the load is performed.
- R10: `word_done` is high for exactly one cycle, while `slot` is 0, right after a circulation that carried a load or a shift. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data for a load, least significant bit first |
| load_req | input | 1 | Request to load during the next circulation |
| shift_req | input | 1 | Request to shift during the next circulation |
| shift_left | input | 1 | Shift direction: 1 = left (toward the MSB), 0 = right |
| shift_amt | input | 2 | Number of positions to shift, 0 to 3 |
| ser_out | output | 1 | Loop tap: the stored bit in the current slot |
| slot | output | 5 | Current slot number, 0 to 19 |
| word_done | output | 1 | One-cycle pulse after a load or shift circulation |

## Verification
The assertions check these on every cycle: that the slot counter steps and wraps, that the gap slots are silent at the tap, that requests are taken only at the boundary, and that the completion pulse sits on slot 0 and lasts one cycle. The values that result from a load or a shift can only be shown by the bench. It loads and shifts words through a table of cases and reads each result back from the tap one circulation later. Directed cases cover requests outside the boundary, a load and a shift requested together, and the edge amounts of 0 and 3 positions.

// File: rtl/circ_word_reg.sv
module circ_word_reg #(
  parameter int DATA_W    = 16,
  parameter int GAP_W     = 4,
  parameter int MAX_SHIFT = 3,
  localparam int WORD_T   = DATA_W + GAP_W,
  localparam int SLOT_W   = $clog2(WORD_T),
  localparam int AMT_W    = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              load_req,
  input  logic              shift_req,
  input  logic              shift_left,
  input  logic [AMT_W-1:0]  shift_amt,
  output logic              ser_out,
  output logic [SLOT_W-1:0] slot,
  output logic              word_done
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WORD_T - 1);

  logic [WORD_T-1:0]    loop_q;
  logic [MAX_SHIFT-1:0] ext_q;
  logic [SLOT_W-1:0]    slot_q;
  logic                 op_load_q, op_shift_q, op_left_q, done_q;
  logic [AMT_W-1:0]     op_amt_q;
  logic                 wb_bit, early_tap, late_tap;
  logic                 boundary;

  assign ser_out   = loop_q[0];
  assign slot      = slot_q;
  assign word_done = done_q;
  assign boundary  = (slot_q == LAST);

  // pick the tap that shortens (early) or lengthens (late) the loop by op_amt_q
  always_comb begin
    early_tap = loop_q[0];
    late_tap  = loop_q[0];
    for (int j = 1; j <= MAX_SHIFT; j++) begin
      if (j == int'(op_amt_q)) begin
        early_tap = loop_q[j];
        late_tap  = ext_q[j-1];
      end
    end
  end

  always_comb begin
    wb_bit = 1'b0;
    if (int'(slot_q) < DATA_W) begin
      if (op_load_q)
        wb_bit = ser_in;
      else if (op_shift_q && !op_left_q)
        wb_bit = (int'(slot_q) + int'(op_amt_q) < DATA_W) ? early_tap : 1'b0;
      else if (op_shift_q && op_left_q)
        wb_bit = (int'(slot_q) >= int'(op_amt_q)) ? late_tap : 1'b0;
      else
        wb_bit = loop_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_q     <= '0;
      ext_q      <= '0;
      slot_q     <= '0;
      op_load_q  <= 1'b0;
      op_shift_q <= 1'b0;
      op_left_q  <= 1'b0;
      op_amt_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      loop_q <= {wb_bit, loop_q[WORD_T-1:1]};
      ext_q  <= (ext_q << 1) | MAX_SHIFT'(loop_q[0]);
      slot_q <= boundary ? '0 : slot_q + 1'b1;
      done_q <= boundary && (op_load_q || op_shift_q);
      if (boundary) begin
        op_load_q  <= load_req;
        op_shift_q <= shift_req && !load_req;
        op_left_q  <= shift_left;
        op_amt_q   <= shift_amt;
      end
    end
  end

  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == LAST) |=> (slot_q == '0));
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  p_gap_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_q) >= DATA_W) |-> (ser_out == 1'b0));
  p_op_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != '0) |-> ($stable(op_load_q) && $stable(op_shift_q)));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_load_q && op_shift_q));
  p_done_slot0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (slot_q == '0));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

endmodule

// File: tb/tb_circ_word_reg.sv
module tb_circ_word_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0, load_req = 1'b0, shift_req = 1'b0, shift_left = 1'b0;
  logic [1:0] shift_amt = '0;
  logic       ser_out, word_done;
  logic [4:0] slot;

  int checks = 0;
  int fails  = 0;

  circ_word_reg dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .load_req(load_req),
    .shift_req(shift_req), .shift_left(shift_left), .shift_amt(shift_amt),
    .ser_out(ser_out), .slot(slot), .word_done(word_done)
  );

  always #10 clk = ~clk;

  // kind: 0 load, 1 shift right, 2 shift left, 3 idle | amt | data | expected
  localparam logic [35:0] VEC [14] = '{
    {2'd0, 2'd0, 16'hA5C3, 16'hA5C3},
    {2'd1, 2'd1, 16'h0000, 16'h52E1},
    {2'd2, 2'd2, 16'h0000, 16'h4B84},
    {2'd3, 2'd0, 16'h0000, 16'h4B84},
    {2'd1, 2'd3, 16'h0000, 16'h0970},
    {2'd2, 2'd0, 16'h0000, 16'h0970},
    {2'd0, 2'd0, 16'hFFFF, 16'hFFFF},
    {2'd2, 2'd3, 16'h0000, 16'hFFF8},
    {2'd1, 2'd2, 16'h0000, 16'h3FFE},
    {2'd0, 2'd0, 16'h8001, 16'h8001},
    {2'd1, 2'd0, 16'h0000, 16'h8001},
    {2'd2, 2'd1, 16'h0000, 16'h0002},
    {2'd0, 2'd0, 16'h0000, 16'h0000},
    {2'd1, 2'd1, 16'h0000, 16'h0000}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_slot(input logic [4:0] s);
    do @(negedge clk); while (slot != s);
  endtask

  // raise requests at slot 19, then feed the load circulation; returns at slot 0 of the next one
  task automatic run_op(input logic [1:0] kind, input logic [1:0] amt, input logic [15:0] data,
                        input logic both);
    wait_slot(5'd19);
    load_req   = (kind == 2'd0);
    shift_req  = (kind == 2'd1) || (kind == 2'd2) || both;
    shift_left = (kind == 2'd2);
    shift_amt  = both ? 2'd3 : amt;
    @(negedge clk);
    load_req  = 1'b0;
    shift_req = 1'b0;
    for (int s = 0; s < 20; s++) begin
      ser_in = (kind == 2'd0 && s < 16) ? data[s] : (kind != 2'd0);
      @(negedge clk);
    end
    ser_in = 1'b0;
  endtask

  // entered at a negedge with slot 0; reads one whole circulation
  task automatic readout(input logic [15:0] exp, input logic exp_done, input string tag);
    logic [15:0] got = '0;
    logic slot_ok = 1'b1;
    logic gap_ok = 1'b1;
    check(word_done == exp_done, {tag, " R10 done pulse"}, 32'(word_done), 32'(exp_done));
    for (int s = 0; s < 20; s++) begin
      if (slot != 5'(s)) slot_ok = 1'b0;
      if (s < 16) got[s] = ser_out;
      else if (ser_out) gap_ok = 1'b0;
      if (s < 19) @(negedge clk);
    end
    check(slot_ok, {tag, " R1 slot sequence"}, 32'(slot_ok), 32'd1);
    check(gap_ok, {tag, " R4 gap silent"}, 32'(gap_ok), 32'd1);
    check(got == exp, {tag, " R3/R5/R7/R8 word"}, 32'(got), 32'(exp));
    @(negedge clk);
    check(word_done == 1'b0, {tag, " R10 no pulse after idle"}, 32'(word_done), 32'd0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(slot == 5'd0, "R2 reset slot", 32'(slot), 32'd0);
    check(ser_out == 1'b0, "R2 reset ser_out", 32'(ser_out), 32'd0);
    check(word_done == 1'b0, "R2 reset word_done", 32'(word_done), 32'd0);
    rst_n = 1'b1;
    wait_slot(5'd0);
    readout(16'h0000, 1'b0, "R2 cleared word");

    for (int i = 0; i < 14; i++) begin
      run_op(VEC[i][35:34], VEC[i][33:32], VEC[i][31:16], 1'b0);
      readout(VEC[i][15:0], VEC[i][35:34] != 2'd3, $sformatf("vec%0d", i));
    end

    // R6: requests and ser_in outside the boundary slot
    run_op(2'd0, 2'd0, 16'h1234, 1'b0);
    readout(16'h1234, 1'b1, "R5 load 1234");
    wait_slot(5'd0);
    for (int s = 0; s < 19; s++) begin
      load_req  = (s % 3 == 1);
      shift_req = (s % 3 == 2);
      shift_amt = 2'd3;
      ser_in    = 1'b1;
      @(negedge clk);
    end
    load_req = 1'b0; shift_req = 1'b0; ser_in = 1'b0;
    @(negedge clk);
    readout(16'h1234, 1'b0, "R6 mid-word requests");

    // R9: load and shift requested together
    run_op(2'd0, 2'd0, 16'h00F0, 1'b1);
    readout(16'h00F0, 1'b1, "R9 load priority");

    // R3: several idle circulations leave the word unchanged
    wait_slot(5'd0);
    repeat (40) @(negedge clk);
    readout(16'h00F0, 1'b0, "R3 long idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule